// File: doc/BRIEF.md
# Power Button and Alarm Event Controller

This block keeps the power-management event status for a front-panel power button and a real-time-clock alarm. Each status bit is set by hardware on the rising edge of its input, after a two-flop synchroniser. Software reads the bits through a small 8-bit register port and clears them by writing ones. An enable register chooses which events may interrupt the running system.

The system state input says whether the system is working, sleeping or in soft off. In the working state, an enabled event drives the system control interrupt (`sci`). In a sleeping or soft-off state, events drive `wake` instead. A button event always wakes, whatever its enable bit holds. An alarm wakes only when its enable bit is set.

A long-press override can be enabled. If the synchronised button stays asserted for `CLK_HZ*HOLD_SEC` clock ticks, the block does three things: it clears the button status, sets an override status bit and latches the `soft_off` output. `soft_off` stays set until reset. An alarm that arrives while standby power is absent is recorded only when alarm-remember is enabled.

Top module: `pm_event_ctrl`

## Requirements
- R1: After reset, both registers read 00h and `sci`, `wake` and `soft_off` are low.
- R2: The button status bit (status register at address 0, bit 0) sets on the third rising clock edge after `btn_in` rises, counting the edge that first samples it.
- R3: Writing 1 to a status bit at address 0 clears it. Writing 0 leaves it unchanged. Reading address 0 returns 0 in bits 7:3.
- R4: When a hardware set and a software write-one-clear reach the same status bit at the same edge, the bit ends up set.
- R5: In the working state (`sys_state` = 0), `sci` is high exactly when (button status and button enable) or (alarm status and alarm enable) holds. The alarm status is status bit 1. The enables are enable-register bits 0 and 1.
- R6: When `sys_state` is non-zero or `soft_off` is high, `sci` is low. In that case `wake` is high when the button status is set, regardless of its enable, or when both the alarm status and the alarm enable are set.
- R7: An alarm rising edge sets the alarm status when `vtr_present` is high. When `vtr_present` is low, it sets the alarm status only if alarm-remember (enable bit 3) is set.
- R8: With override enable (enable bit 2) set and `btn_in` held, `soft_off` rises on edge HOLD+3 after the press, where HOLD is `CLK_HZ*HOLD_SEC`. At that same edge the button status clears and the override status (status bit 2) sets. `soft_off` then stays high until reset.
- R9: If the button is released before the override fires, the hold count restarts from zero.
- R10: The enable register at address 1 is read/write in bits 3:0 and reads 0 in bits 7:4. Addresses 2 and 3 read 00h and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (battery power-on) |
| btn_in | input | 1 | Power button, asynchronous, high when pressed |
| alarm_in | input | 1 | RTC alarm request, asynchronous |
| vtr_present | input | 1 | Standby power present, asynchronous |
| sys_state | input | 2 | 0 working, 1 sleeping, 2 soft off, 3 treated as sleeping |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| sci | output | 1 | System control interrupt |
| wake | output | 1 | Wake event |
| soft_off | output | 1 | Forced soft off, power-on released |

## Verification
A stuck or wrong status bit shows up at once on `reg_rdata` and, through the enable gating, on `sci` or `wake` in the same cycle. An off-by-one in the synchroniser or edge detector moves the status set by one edge, and the bench samples each side of the expected edge. A hold counter that fails to restart, or that fires one tick early or late, changes the edge on which `soft_off` rises. The bench pins that edge exactly, and it also runs two short presses that together exceed the hold time.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;

    typedef enum logic [1:0] {
        ST_WORK    = 2'd0,
        ST_SLEEP   = 2'd1,
        ST_SOFTOFF = 2'd2,
        ST_RSVD    = 2'd3
    } pwr_state_e;

    localparam logic [1:0] ADDR_STS = 2'd0;
    localparam logic [1:0] ADDR_EN  = 2'd1;

    localparam int STS_W = 3;
    localparam int EN_W  = 4;

    // bit 0 button, bit 1 alarm, bit 2 override
    typedef struct packed {
        logic ovr;
        logic rtc;
        logic btn;
    } sts_t;

    // bit 0 button, bit 1 alarm, bit 2 override, bit 3 alarm-remember
    typedef struct packed {
        logic arm;
        logic ovr;
        logic rtc;
        logic btn;
    } en_t;

    function automatic logic [7:0] sts_byte(sts_t s);
        return {{(8-STS_W){1'b0}}, s};
    endfunction

    function automatic logic [7:0] en_byte(en_t e);
        return {{(8-EN_W){1'b0}}, e};
    endfunction

    function automatic logic is_asleep(pwr_state_e st, logic off);
        return (st != ST_WORK) || off;
    endfunction

endpackage

// File: rtl/pm_sync.sv
module pm_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= 1'b0;
                s2 <= 1'b0;
            end else begin
                s1 <= d[i];
                s2 <= s1;
            end
        end
        assign q[i] = s2;
    end
endmodule

// File: rtl/pm_ovr_timer.sv
module pm_ovr_timer #(
    parameter int HOLD_TICKS = 131072
) (
    input  logic clk,
    input  logic rst,
    input  logic btn_s,
    input  logic arm,
    output logic fire
);
    localparam int CW = $clog2(HOLD_TICKS + 2);
    localparam logic [CW-1:0] HOLD_V = CW'(HOLD_TICKS);
    localparam logic [CW-1:0] DONE_V = CW'(HOLD_TICKS + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !btn_s || !arm) begin
            cnt_q <= '0;
        end else if (cnt_q != DONE_V) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign fire = btn_s && arm && (cnt_q == HOLD_V);
endmodule

// File: rtl/pm_event_ctrl.sv
module pm_event_ctrl
    import pm_evt_pkg::*;
#(
    parameter int CLK_HZ   = 32768,
    parameter int HOLD_SEC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       btn_in,
    input  logic       alarm_in,
    input  logic       vtr_present,
    input  logic [1:0] sys_state,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       sci,
    output logic       wake,
    output logic       soft_off
);
    localparam int HOLD_TICKS = CLK_HZ * HOLD_SEC;

    logic [2:0] sync_q;
    logic [1:0] prev_q;
    logic       btn_s, alarm_s, vtr_s;
    logic       btn_rise, alarm_rise, rtc_set;
    logic       ovr_fire;
    logic [3:0] wdata_unused;
    sts_t       sts_q, sts_d;
    en_t        en_q;
    logic       off_q;
    pwr_state_e st;

    assign wdata_unused = reg_wdata[7:4];
    assign st = pwr_state_e'(sys_state);

    pm_sync #(.W(3)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({vtr_present, alarm_in, btn_in}),
        .q   (sync_q)
    );

    assign btn_s   = sync_q[0];
    assign alarm_s = sync_q[1];
    assign vtr_s   = sync_q[2];

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= {alarm_s, btn_s};
    end

    assign btn_rise   = btn_s   && !prev_q[0];
    assign alarm_rise = alarm_s && !prev_q[1];
    assign rtc_set    = alarm_rise && (vtr_s || en_q.arm);

    pm_ovr_timer #(.HOLD_TICKS(HOLD_TICKS)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .btn_s (btn_s),
        .arm   (en_q.ovr),
        .fire  (ovr_fire)
    );

    // clear first, then the override, then hardware sets, so sets win
    always_comb begin
        sts_d = sts_q;
        if (reg_wr && reg_addr == ADDR_STS) begin
            sts_d = sts_d & ~sts_t'(reg_wdata[STS_W-1:0]);
        end
        if (ovr_fire) begin
            sts_d.btn = 1'b0;
            sts_d.ovr = 1'b1;
        end
        if (btn_rise) sts_d.btn = 1'b1;
        if (rtc_set)  sts_d.rtc = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sts_q <= '0;
            en_q  <= '0;
            off_q <= 1'b0;
        end else begin
            sts_q <= sts_d;
            if (reg_wr && reg_addr == ADDR_EN) en_q <= en_t'(reg_wdata[EN_W-1:0]);
            if (ovr_fire) off_q <= 1'b1;
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_STS: reg_rdata = sts_byte(sts_q);
            ADDR_EN:  reg_rdata = en_byte(en_q);
            default:  reg_rdata = 8'h00;
        endcase
    end

    logic asleep;
    logic rtc_evt;
    assign asleep  = is_asleep(st, off_q);
    assign rtc_evt = sts_q.rtc && en_q.rtc;
    assign sci      = !asleep && ((sts_q.btn && en_q.btn) || rtc_evt);
    assign wake     = asleep && (sts_q.btn || rtc_evt);
    assign soft_off = off_q;
endmodule

// File: rtl/pm_event_ctrl_chk.sv
module pm_event_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] sys_state,
    input logic       reg_wr,
    input logic [1:0] reg_addr,
    input logic [7:0] reg_wdata,
    input logic [7:0] reg_rdata,
    input logic [2:0] sts,
    input logic [3:0] en,
    input logic       sci,
    input logic       wake,
    input logic       soft_off
);
    // R6
    sci_quiet_asleep_chk: assert property (@(posedge clk) disable iff (rst)
        (sys_state != 2'd0 || soft_off) |-> !sci);

    // R6
    btn_wakes_chk: assert property (@(posedge clk) disable iff (rst)
        ((sys_state != 2'd0 || soft_off) && sts[0]) |-> wake);

    // R3
    zero_write_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == 2'd0 && !reg_wdata[1] && sts[1]) |=> sts[1]);

    // R8
    soft_off_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        soft_off |=> soft_off);

    // R8
    override_status_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(soft_off) |-> (sts[2] && !sts[0]));

    // R8
    override_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        !en[2] |=> !$rose(soft_off));

    // R10
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[7:4] == 4'h0);
endmodule

bind pm_event_ctrl pm_event_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sys_state (sys_state),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .sts       (sts_q),
    .en        (en_q),
    .sci       (sci),
    .wake      (wake),
    .soft_off  (soft_off)
);

// File: tb/sim_pm_event_ctrl.sv
module sim_pm_event_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int HZ   = 5;
    localparam int SEC  = 4;
    localparam int HOLD = HZ * SEC;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       btn_in = 1'b0, alarm_in = 1'b0, vtr_present = 1'b1;
    logic [1:0] sys_state = 2'd0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sci, wake, soft_off;

    int checks = 0, fails = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pm_event_ctrl #(.CLK_HZ(HZ), .HOLD_SEC(SEC)) u0 (
        .clk(clk), .rst(rst), .btn_in(btn_in), .alarm_in(alarm_in),
        .vtr_present(vtr_present), .sys_state(sys_state), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sci(sci), .wake(wake), .soft_off(soft_off)
    );

    // {wr, addr[1:0], wdata[7:0], expected read of addr[7:0]}
    localparam logic [18:0] VEC [8] = '{
        {1'b1, 2'd1, 8'hFF, 8'h0F},
        {1'b1, 2'd1, 8'h05, 8'h05},
        {1'b1, 2'd1, 8'hA2, 8'h02},
        {1'b1, 2'd2, 8'hFF, 8'h00},
        {1'b0, 2'd1, 8'h00, 8'h02},
        {1'b0, 2'd0, 8'h00, 8'h00},
        {1'b1, 2'd0, 8'hFF, 8'h00},
        {1'b1, 2'd1, 8'h00, 8'h00}
    };

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick(1);
        reg_wr = 1'b0;
    endtask

    task automatic rd(string tag, logic [1:0] a, logic [7:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic outs(string tag, logic s, logic w, logic o);
        #1;
        chk(tag, {5'b0, s, w, o}, {5'b0, sci, wake, soft_off} ^ {5'b0, s, w, o} ^ {5'b0, s, w, o});
        checks--;
        chk(tag, {5'b0, sci, wake, soft_off}, {5'b0, s, w, o});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        rd("R1 status", 2'd0, 8'h00);
        rd("R1 enable", 2'd1, 8'h00);
        outs("R1 outputs", 1'b0, 1'b0, 1'b0);

        // R10 register table
        for (int i = 0; i < 8; i++) begin
            if (VEC[i][18]) wr(VEC[i][17:16], VEC[i][15:8]);
            rd("R10 table", VEC[i][17:16], VEC[i][7:0]);
        end

        // R2 button status timing
        @(negedge clk);
        btn_in = 1'b1;
        tick(2);
        rd("R2 before edge", 2'd0, 8'h00);
        tick(1);
        rd("R2 set", 2'd0, 8'h01);
        btn_in = 1'b0;
        tick(3);

        // R6 wake ignores button enable
        sys_state = 2'd1;
        outs("R6 sleep wake", 1'b0, 1'b1, 1'b0);
        sys_state = 2'd2;
        outs("R6 softoff wake", 1'b0, 1'b1, 1'b0);
        sys_state = 2'd0;
        outs("R5 no enable", 1'b0, 1'b0, 1'b0);

        // R5 enabled button raises sci
        wr(2'd1, 8'h01);
        outs("R5 sci", 1'b1, 1'b0, 1'b0);

        // R3 write zero / write one
        wr(2'd0, 8'h00);
        rd("R3 zero write", 2'd0, 8'h01);
        wr(2'd0, 8'h01);
        rd("R3 one clears", 2'd0, 8'h00);
        outs("R5 sci drops", 1'b0, 1'b0, 1'b0);

        // R7 alarm with standby power
        wr(2'd1, 8'h02);
        alarm_in = 1'b1;
        tick(3);
        alarm_in = 1'b0;
        rd("R7 alarm set", 2'd0, 8'h02);
        outs("R5 rtc sci", 1'b1, 1'b0, 1'b0);
        wr(2'd0, 8'h02);
        tick(3);
        vtr_present = 1'b0;
        tick(3);
        alarm_in = 1'b1;
        tick(4);
        alarm_in = 1'b0;
        tick(2);
        rd("R7 alarm lost", 2'd0, 8'h00);
        wr(2'd1, 8'h0A);
        alarm_in = 1'b1;
        tick(4);
        alarm_in = 1'b0;
        rd("R7 alarm remembered", 2'd0, 8'h02);
        sys_state = 2'd1;
        outs("R6 rtc wake", 1'b0, 1'b1, 1'b0);
        sys_state = 2'd0;
        wr(2'd0, 8'h02);
        vtr_present = 1'b1;
        wr(2'd1, 8'h00);
        tick(3);

        // R4 set beats clear at the same edge
        btn_in = 1'b1;
        tick(2);
        wr(2'd0, 8'h01);
        rd("R4 set wins", 2'd0, 8'h01);
        wr(2'd0, 8'h01);
        rd("R4 later clear", 2'd0, 8'h00);
        btn_in = 1'b0;
        tick(3);

        // R9 release restarts hold count
        wr(2'd1, 8'h04);
        btn_in = 1'b1;
        tick(HOLD - 3);
        btn_in = 1'b0;
        tick(4);
        btn_in = 1'b1;
        tick(HOLD - 3);
        btn_in = 1'b0;
        tick(4);
        outs("R9 no override", 1'b0, 1'b0, 1'b0);
        rd("R9 status", 2'd0, 8'h01);
        wr(2'd0, 8'h07);

        // R8 override at exact edge
        btn_in = 1'b1;
        tick(HOLD + 2);
        outs("R8 before expiry", 1'b0, 1'b0, 1'b0);
        tick(1);
        outs("R8 soft off", 1'b0, 1'b0, 1'b1);
        rd("R8 status", 2'd0, 8'h04);
        btn_in = 1'b0;
        tick(4);
        outs("R8 sticky", 1'b0, 1'b0, 1'b1);
        btn_in = 1'b1;
        tick(3);
        outs("R6 wake in soft off", 1'b0, 1'b1, 1'b1);
        btn_in = 1'b0;

        // R1 reset again
        rst = 1'b1;
        tick(2);
        rst = 1'b0;
        tick(1);
        rd("R1 status after", 2'd0, 8'h00);
        rd("R1 enable after", 2'd1, 8'h00);
        outs("R1 outputs after", 1'b0, 1'b0, 1'b0);

        finish_run();
    end
endmodule